// File: doc/BRIEF.md
# Redundant Pipeline Stage Code Combiner

This block is the digital back end of a pipelined analog-to-digital converter built from `NUM_STAGES` stages. Every stage except the last resolves a redundant 1.5-bit decision (three legal codes). The last stage is a plain 2-bit flash. All stage codes arrive together on one bus every clock. Each code belongs to a different sample, because stage `i` decides on a given sample `i` clocks after stage 0 does.

Each stage's code goes through its own delay line. The earliest stage is held the longest and the last stage is not held at all, so that every code of one sample meets in the same cycle. The aligned codes are then summed with weights that halve from stage to stage. Adjacent weights overlap by one bit, which is what lets the digital sum absorb comparator threshold errors in the analog stages without any subtraction. One word per clock comes out at a fixed latency, and a valid strobe travels with the data.

Top module: `pipeline_code_combiner`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_word` is 0.
- R2: Stage `i` occupies bits `[2i+1:2i]` of `in_codes`, with stage 0 the earliest decision. The code of stage `i` is combined with the sample whose stage-0 code arrived `i` clocks earlier. That sample's result appears at the ports `NUM_STAGES` clocks after the clock edge that captured its stage-0 code.
- R3: A code of a 1.5-bit stage `i` (`i` < `NUM_STAGES`-1) is read as an unsigned value (00=0, 01=1, 10=2) and weighted by 2^(`NUM_STAGES`-1-`i`). The last stage code (00..11 = 0..3) is weighted by 1. `out_word` is the sum of the weighted codes.
- R4: A 1.5-bit stage code of 11 counts as 3. When the sum exceeds 2^(`NUM_STAGES`+1)-1, `out_word` is clipped to that maximum instead of wrapping.
- R5: The stages may decide with comparator thresholds moved from ±VREF/4 by any amount smaller than VREF/4 in magnitude, as long as the residues follow the stage transfer (2·v−VREF for 10, 2·v for 01, 2·v+VREF for 00). The word is then identical to floor((vin/VREF+1)·2^`NUM_STAGES`), the result with ideal thresholds.
- R6: Exactly one `out_valid` pulse is produced for each cycle with `in_valid` high, in order and back to back. Cycles with `in_valid` low produce no pulse, and nothing is emitted while the pipeline fills.
- R7: While `out_valid` is 0, `out_word` keeps its last value.
- R8: A reset taken while samples are in flight discards them: no `out_valid` pulse appears for them.
- R9: All codes 00 give word 0. All 1.5-bit codes 10 with a last-stage code 11 give the full-scale word 2^(`NUM_STAGES`+1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new sample's stage-0 code is on the bus this cycle |
| in_codes | input | 2*NUM_STAGES | Per-stage codes, stage `i` at bits `[2i+1:2i]` |
| out_valid | output | 1 | `out_word` holds a new corrected result |
| out_word | output | NUM_STAGES+1 | Corrected, clipped output word |

## Verification
The bench models the analog stages, including several comparator offset patterns, and compares the port result against the ideal quantisation of the input. A wrong internal state therefore shows up directly at the ports. A stale or misrouted delay tap gives a wrong word at one stage's weight for the first affected sample, `NUM_STAGES` clocks after its stage-0 code entered. A corrupted strobe chain gives a missing, extra or shifted `out_valid` pulse at the same latency. A bad hold or reset path shows as `out_word` changing in an idle cycle, or as a pulse within `NUM_STAGES` clocks after reset.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  // One stage decision: 2 bits, unsigned value 0..3.
  typedef logic [1:0] stage_code_t;

  // Left shift applied to stage idx; the last stage (flash) has weight 1,
  // each earlier stage doubles the weight of the next.
  function automatic int unsigned stage_weight_shift(input int unsigned n_stages,
                                                     input int unsigned idx);
    if (idx + 1 >= n_stages)
      return 0;
    return n_stages - 1 - idx;
  endfunction

endpackage

// File: rtl/pcc_delay_line.sv
// Plain data delay without reset so that shift-register primitives can be used.
module pcc_delay_line #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    taps[0] <= d;
    for (int k = 1; k < DEPTH; k++) begin
      taps[k] <= taps[k-1];
    end
  end

  assign q = taps[DEPTH-1];

endmodule

// File: rtl/pcc_overlap_adder.sv
// Weighted sum of time-aligned stage codes with clipping to the output range.
module pcc_overlap_adder #(
  parameter int NUM_STAGES = 8
) (
  input  logic [2*NUM_STAGES-1:0] aligned,
  output logic [NUM_STAGES:0]     word
);
  import pcc_pkg::*;

  localparam int OUT_W = NUM_STAGES + 1;
  localparam int SUM_W = OUT_W + 1;
  localparam logic [SUM_W-1:0] MAX_WORD = {1'b0, {OUT_W{1'b1}}};

  logic [SUM_W-1:0] term [NUM_STAGES];
  logic [SUM_W-1:0] acc;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_STAGES; gi++) begin : g_term
      stage_code_t code;
      assign code     = aligned[2*gi +: 2];
      assign term[gi] = SUM_W'(code) << stage_weight_shift(NUM_STAGES, gi);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_STAGES; i++) begin
      acc = acc + term[i];
    end
  end

  assign word = (acc > MAX_WORD) ? MAX_WORD[OUT_W-1:0] : acc[OUT_W-1:0];

endmodule

// File: rtl/pipeline_code_combiner.sv
module pipeline_code_combiner #(
  parameter int NUM_STAGES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2*NUM_STAGES-1:0] in_codes,
  output logic                    out_valid,
  output logic [NUM_STAGES:0]     out_word
);

  localparam int OUT_W  = NUM_STAGES + 1;
  localparam int VDEPTH = NUM_STAGES - 1;

  logic [2*NUM_STAGES-1:0] aligned;
  logic [VDEPTH-1:0]       vpipe;
  logic                    aligned_valid;
  logic [OUT_W-1:0]        corrected;

  // Stage i is delayed NUM_STAGES-1-i clocks; the last stage passes through.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_STAGES; gi++) begin : g_align
      if (gi == NUM_STAGES - 1) begin : g_pass
        assign aligned[2*gi +: 2] = in_codes[2*gi +: 2];
      end else begin : g_dly
        pcc_delay_line #(
          .WIDTH (2),
          .DEPTH (NUM_STAGES - 1 - gi)
        ) u_dly (
          .clk (clk),
          .d   (in_codes[2*gi +: 2]),
          .q   (aligned[2*gi +: 2])
        );
      end
    end
  endgenerate

  // Strobe follows stage 0's path, with reset so flushed samples vanish.
  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
    end else begin
      vpipe[0] <= in_valid;
      for (int k = 1; k < VDEPTH; k++) begin
        vpipe[k] <= vpipe[k-1];
      end
    end
  end

  assign aligned_valid = vpipe[VDEPTH-1];

  pcc_overlap_adder #(
    .NUM_STAGES (NUM_STAGES)
  ) u_sum (
    .aligned (aligned),
    .word    (corrected)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= aligned_valid;
      if (aligned_valid) begin
        out_word <= corrected;
      end
    end
  end

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int NUM_STAGES = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic [NUM_STAGES:0]   out_word
);

  logic [NUM_STAGES-1:0] vref;
  int                    since_rst;
  logic                  warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      vref      <= '0;
      since_rst <= 0;
      warm      <= 1'b0;
    end else begin
      vref[0] <= in_valid;
      for (int k = 1; k < NUM_STAGES; k++) begin
        vref[k] <= vref[k-1];
      end
      if (since_rst < NUM_STAGES) since_rst <= since_rst + 1;
      warm <= 1'b1;
    end
  end

  // R1: reset leaves the outputs cleared
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == '0));

  // R6: one strobe per accepted sample, exactly NUM_STAGES clocks later
  a_r6_strobe_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vref[NUM_STAGES-1]);

  // R7: word frozen while no strobe
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (warm && !out_valid) |-> $stable(out_word));

  // R8: nothing emerges before a full latency after reset
  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    (since_rst < NUM_STAGES) |-> !out_valid);

endmodule

bind pipeline_code_combiner pcc_checker #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_word  (out_word)
);

// File: tb/tb_pipeline_code_combiner.sv
module tb_pipeline_code_combiner;

  localparam int     N  = 8;
  localparam int     S  = 264;
  localparam longint V  = 64'sd1 << 20;
  localparam int     SH = 20 - N;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [2*N-1:0] in_codes = '0;
  logic           out_valid;
  logic [N:0]     out_word;

  pipeline_code_combiner #(.NUM_STAGES(N)) dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_codes (in_codes),
    .out_valid (out_valid), .out_word (out_word)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [2*N-1:0] t_codes [S];
  logic           t_vld   [S];
  logic [N:0]     t_exp   [S];
  string          t_tag   [S];

  int         q_due [$];
  logic [N:0] q_exp [$];
  string      q_tag [$];
  logic [N:0] last_word = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint off_hi(input int i, input int mode);
    case (mode)
      1: return (i % 2 == 0) ? (V/4 - 1) : -(V/4 - 1);
      2: return -(V/4 - 1);
      3: return longint'(i) * V / 16 - V / 5;
      default: return 0;
    endcase
  endfunction

  function automatic longint off_lo(input int i, input int mode);
    case (mode)
      1: return (i % 2 == 0) ? -(V/4 - 1) : (V/4 - 1);
      2: return (V/4 - 1);
      3: return V / 5 - longint'(i) * V / 20;
      default: return 0;
    endcase
  endfunction

  // Analog stage model: comparators with offsets, exact residue transfer.
  function automatic logic [2*N-1:0] model(input longint vin, input int mode);
    longint x;
    longint hi;
    longint lo;
    int c;
    logic [2*N-1:0] v;
    x = vin;
    v = '0;
    for (int i = 0; i < N - 1; i++) begin
      hi = V/4 + off_hi(i, mode);
      lo = -V/4 + off_lo(i, mode);
      if (x >= hi) c = 2;
      else if (x < lo) c = 0;
      else c = 1;
      v[2*i +: 2] = 2'(c);
      x = 2*x - longint'(c - 1) * V;
    end
    if (x < -V/2) c = 0;
    else if (x < 0) c = 1;
    else if (x < V/2) c = 2;
    else c = 3;
    v[2*(N-1) +: 2] = 2'(c);
    return v;
  endfunction

  // Ideal quantisation of vin (R5): floor((vin/V + 1) * 2^N)
  function automatic logic [N:0] ideal(input longint vin);
    longint e;
    e = (vin + V) >>> SH;
    if (e > (64'sd1 << (N+1)) - 1) e = (64'sd1 << (N+1)) - 1;
    return (N+1)'(e);
  endfunction

  task automatic run_stream(input int base, input int len, input bit push);
    for (int step = 0; step < len + N - 1; step++) begin
      logic [2*N-1:0] v;
      v = '0;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (step - i >= 0 && step - i < len)
          v[2*i +: 2] = t_codes[base + step - i][2*i +: 2];
      end
      in_codes = v;
      in_valid = (step < len) ? t_vld[base + step] : 1'b0;
      if (push && in_valid) begin
        q_due.push_back(cyc + N);
        q_exp.push_back(t_exp[base + step]);
        q_tag.push_back(t_tag[base + step]);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_codes = '0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      last_word = '0;
    end else begin
      if (q_due.size() > 0 && q_due[0] < cyc) begin
        chk(1'b0, q_tag[0], "result missing at due cycle", cyc, q_due[0]);
        void'(q_due.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
      end
      if (out_valid) begin
        if (q_due.size() == 0 || q_due[0] != cyc) begin
          chk(1'b0, "R6/R8", "unexpected out_valid at cycle", cyc,
              (q_due.size() > 0) ? q_due[0] : -1);
        end else begin
          chk(out_word == q_exp[0], q_tag[0], "out_word", int'(out_word), int'(q_exp[0]));
          chk(1'b1, "R2", "latency", cyc, q_due[0]);
          last_word = out_word;
          void'(q_due.pop_front()); void'(q_exp.pop_front()); void'(q_tag.pop_front());
        end
      end else begin
        chk(out_word == last_word, "R7", "idle hold", int'(out_word), int'(last_word));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    longint st;
    longint vin;
    st = 64'sd12345;
    // R3: ramp with ideal comparators
    for (int s = 0; s < 64; s++) begin
      vin = -V + longint'(s) * 32768 + longint'(s) * 97;
      t_codes[s] = model(vin, 0); t_vld[s] = 1'b1; t_exp[s] = ideal(vin); t_tag[s] = "R3";
    end
    // R5: pseudo-random inputs with two offset patterns; R6: bubbles
    for (int s = 64; s < 256; s++) begin
      st  = (st * 1103515245 + 12345) % (64'sd1 << 31);
      vin = (st % (2 * V)) - V;
      t_codes[s] = model(vin, (s < 128) ? 1 : (s < 192) ? 2 : 3);
      t_vld[s]   = (s >= 128 && s < 192) ? (s % 3 != 1) : 1'b1;
      t_exp[s]   = ideal(vin);
      t_tag[s]   = (s >= 128 && s < 192) ? "R6" : "R5";
    end
    for (int s = 256; s < S; s++) begin
      t_vld[s] = 1'b1;
      t_codes[s] = '0;
    end
    // R9: all zero
    t_exp[256] = 0; t_tag[256] = "R9";
    // R9: full scale
    for (int i = 0; i < N - 1; i++) t_codes[257][2*i +: 2] = 2'b10;
    t_codes[257][2*(N-1) +: 2] = 2'b11; t_exp[257] = (N+1)'((1 << (N+1)) - 1); t_tag[257] = "R9";
    // R4: illegal 11 in stage 0 on top of full scale saturates
    t_codes[258] = t_codes[257]; t_codes[258][1:0] = 2'b11;
    t_exp[258] = (N+1)'((1 << (N+1)) - 1); t_tag[258] = "R4";
    // R4: illegal 11 alone counts as 3
    t_codes[259][1:0] = 2'b11; t_exp[259] = (N+1)'(3 << (N-1)); t_tag[259] = "R4";
    // R3: flash only
    t_codes[260][2*(N-1) +: 2] = 2'b11; t_exp[260] = 3; t_tag[260] = "R3";
    // R3: last 1.5-bit stage weight 2
    t_codes[261][2*(N-2) +: 2] = 2'b10; t_exp[261] = 4; t_tag[261] = "R3";
    // R2: earliest stage carries the highest weight
    t_codes[262][1:0] = 2'b01; t_exp[262] = (N+1)'(1 << (N-1)); t_tag[262] = "R2";
    // R4: two illegal codes saturate
    t_codes[263] = t_codes[258]; t_codes[263][3:2] = 2'b11;
    t_exp[263] = (N+1)'((1 << (N+1)) - 1); t_tag[263] = "R4";

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(out_word == '0, "R1", "out_word in reset", int'(out_word), 0);
    rst = 1'b0;

    // R8: samples in flight are dropped by reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_codes = t_codes[k];
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(out_word == '0, "R1", "out_word after reset", int'(out_word), 0);
    rst = 1'b0;
    for (int k = 0; k < N + 4; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "strobe for flushed sample", int'(out_valid), 0);
    end

    run_stream(0, 64, 1'b1);
    repeat (N + 2) @(negedge clk);
    run_stream(64, 64, 1'b1);
    repeat (N + 2) @(negedge clk);
    run_stream(128, 64, 1'b1);
    repeat (N + 2) @(negedge clk);
    run_stream(192, 64, 1'b1);
    repeat (N + 2) @(negedge clk);
    run_stream(256, 8, 1'b1);
    repeat (N + 4) @(negedge clk);

    chk(q_due.size() == 0, "R6", "results still pending", q_due.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule